// File: doc/BRIEF.md
# Redundant Reference Mode and Alarm Controller

This block is the control and status logic for a clock module that has two redundant timing references. Two static control pins pick one of four operating modes: free run, track reference 1, track reference 2 or holdover. The block registers that choice and drives four one-hot mode indicators. It also drives a select and track pair toward a downstream phase-locked loop, which is outside this block.

Each reference input is brought into the local sampling clock domain and watched for rising edges. A reference is declared lost when no edge arrives within a programmable window. It is declared good again only after a long stretch of uninterrupted activity. A single active-high alarm combines three causes: a non-tracking mode (free run or holdover), the loss or non-qualification of the reference in use, and a deasserted lock input from the loop.

The block also keeps the loop's frequency control word for holdover. It captures the word on every cycle in which the loop tracks a reference and is locked, and freezes it otherwise. An output-enable pin, driven from a tri-state request input, controls the clock output pads.

Top module: `refmode_ctrl`

## Requirements
- R1: The registered mode follows the control pins one clock after they are sampled. The encoding is {sel_b, sel_a}: 00 selects free run, 01 selects reference 1, 10 selects reference 2 and 11 selects holdover.
- R2: A synchronous active-high reset puts the block in free run with alarm high, clears all activity and qualification counters, and clears the held control word.
- R3: Exactly one of free_ind, ref1_ind, ref2_ind and hold_ind is high at all times.
- R4: The alarm is high on the cycle after the registered mode is free run or holdover.
- R5: pll_unlock is high while pll_lock is low or the mode is not a tracking mode. The alarm is high on the cycle after pll_lock is sampled low.
- R6: A reference is lost once LOSS_CYC local cycles pass with no synchronized rising edge. In that case the alarm rises while that reference is selected, between LOSS_CYC-4 and LOSS_CYC+4 cycles after its last rising edge reaches the pin.
- R7: After a reference returns, it is qualified only after QUAL_CYC consecutive cycles without loss. A loss during that time restarts the count, and the alarm stays high until qualification completes.
- R8: The activity state of the reference that is not selected has no effect on the alarm.
- R9: out_oe is low while hiz_req is high and high while hiz_req is low, without clock latency.
- R10: fcw_hold takes fcw_in on each clock where the mode is a tracking mode and pll_lock is high. It holds its value in every other cycle, which includes all of holdover.
- R11: ref_sel is 1 only in reference 2 mode. pll_track is 1 only in the two reference modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_a | input | 1 | Mode control bit A |
| sel_b | input | 1 | Mode control bit B |
| ref1_in | input | 1 | Reference clock 1, asynchronous |
| ref2_in | input | 1 | Reference clock 2, asynchronous |
| pll_lock | input | 1 | Lock status from the loop |
| hiz_req | input | 1 | Output tri-state request, 1 = high impedance |
| fcw_in | input | FCW_W | Loop frequency control word |
| free_ind | output | 1 | Free run indicator |
| ref1_ind | output | 1 | Reference 1 indicator |
| ref2_ind | output | 1 | Reference 2 indicator |
| hold_ind | output | 1 | Holdover indicator |
| ref_sel | output | 1 | Loop reference select, 1 = reference 2 |
| pll_track | output | 1 | Loop tracks the selected reference |
| pll_unlock | output | 1 | Loop not locked to a selected reference |
| alarm | output | 1 | Combined active-high alarm |
| out_oe | output | 1 | Clock output pad enable |
| fcw_hold | output | FCW_W | Control word held for holdover |

## Verification
The mode indicators, ref_sel, pll_track and fcw_hold are due one clock after an input is sampled. The alarm is due one clock after the registered mode and the loss state. A reference edge reaches the loss counter three clocks after it reaches the pin. pll_unlock and out_oe follow their inputs within the same cycle. The bench drives inputs 2 ns after a rising edge and compares every output at the falling edge against a behavioural model that advances on each rising edge, so each expected value is matched to the cycle in which it is due. Directed checks bracket the loss and release timing with margins of a few cycles, because the point where a reference stops within its own period varies by a few local cycles.

// File: rtl/refmode_ctrl.sv
module refmode_ctrl #(
  parameter int FCW_W    = 24,
  parameter int LOSS_CYC = 1900,
  parameter int QUAL_CYC = 5000000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_a,
  input  logic             sel_b,
  input  logic             ref1_in,
  input  logic             ref2_in,
  input  logic             pll_lock,
  input  logic             hiz_req,
  input  logic [FCW_W-1:0] fcw_in,
  output logic             free_ind,
  output logic             ref1_ind,
  output logic             ref2_ind,
  output logic             hold_ind,
  output logic             ref_sel,
  output logic             pll_track,
  output logic             pll_unlock,
  output logic             alarm,
  output logic             out_oe,
  output logic [FCW_W-1:0] fcw_hold
);
  localparam int LW = $clog2(LOSS_CYC + 1);
  localparam int QW = $clog2(QUAL_CYC + 1);

  logic [1:0] mode_q;
  logic [1:0] ref_pins;
  logic [1:0] lost, qual;

  assign ref_pins = {ref2_in, ref1_in};

  for (genvar g = 0; g < 2; g++) begin : g_mon
    logic [2:0]    sh;
    logic [LW-1:0] idle_cnt;
    logic [QW-1:0] good_cnt;
    logic          edge_seen;

    assign edge_seen = sh[1] & ~sh[2];
    assign lost[g]   = (idle_cnt == LW'(LOSS_CYC));
    assign qual[g]   = (good_cnt == QW'(QUAL_CYC));

    always_ff @(posedge clk) begin
      if (rst) begin
        sh       <= '0;
        idle_cnt <= '0;
        good_cnt <= '0;
      end else begin
        sh <= {sh[1:0], ref_pins[g]};
        if (edge_seen)
          idle_cnt <= '0;
        else if (!lost[g])
          idle_cnt <= idle_cnt + 1'b1;
        if (lost[g])
          good_cnt <= '0;
        else if (!qual[g])
          good_cnt <= good_cnt + 1'b1;
      end
    end
  end

  logic lor_sel;
  assign pll_track = (mode_q == 2'd1) | (mode_q == 2'd2);
  assign ref_sel   = (mode_q == 2'd2);
  assign lor_sel   = ref_sel ? (lost[1] | ~qual[1]) : (lost[0] | ~qual[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= 2'd0;
      alarm    <= 1'b1;
      fcw_hold <= '0;
    end else begin
      mode_q <= {sel_b, sel_a};
      alarm  <= ~pll_track | lor_sel | ~pll_lock;
      if (pll_track && pll_lock)
        fcw_hold <= fcw_in;
    end
  end

  assign free_ind   = (mode_q == 2'd0);
  assign ref1_ind   = (mode_q == 2'd1);
  assign ref2_ind   = (mode_q == 2'd2);
  assign hold_ind   = (mode_q == 2'd3);
  assign pll_unlock = ~pll_lock | ~pll_track;
  assign out_oe     = ~hiz_req;
endmodule

// File: rtl/refmode_ctrl_chk.sv
module refmode_ctrl_chk #(
  parameter int FCW_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             sel_a,
  input logic             sel_b,
  input logic             pll_lock,
  input logic             free_ind,
  input logic             ref1_ind,
  input logic             ref2_ind,
  input logic             hold_ind,
  input logic             alarm,
  input logic [FCW_W-1:0] fcw_hold
);
  p_reset_state_r2: assert property (@(posedge clk)
    rst |=> (free_ind && alarm && fcw_hold == '0));

  p_decode_ref1_r1: assert property (@(posedge clk) disable iff (rst)
    (sel_a && !sel_b) |=> ref1_ind);

  p_decode_ref2_r1: assert property (@(posedge clk) disable iff (rst)
    (!sel_a && sel_b) |=> ref2_ind);

  p_onehot_ind_r3: assert property (@(posedge clk) disable iff (rst)
    $countones({free_ind, ref1_ind, ref2_ind, hold_ind}) == 1);

  p_mode_alarm_r4: assert property (@(posedge clk) disable iff (rst)
    (free_ind || hold_ind) |=> alarm);

  p_unlock_alarm_r5: assert property (@(posedge clk) disable iff (rst)
    !pll_lock |=> alarm);

  p_hold_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    hold_ind |=> $stable(fcw_hold));
endmodule

bind refmode_ctrl refmode_ctrl_chk #(.FCW_W(FCW_W)) u_chk (
  .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b), .pll_lock(pll_lock),
  .free_ind(free_ind), .ref1_ind(ref1_ind), .ref2_ind(ref2_ind),
  .hold_ind(hold_ind), .alarm(alarm), .fcw_hold(fcw_hold)
);

// File: tb/refmode_ctrl_tb.sv
`timescale 1ns/1ps
module refmode_ctrl_tb;
  localparam int FW = 16;
  localparam int LOSS = 20;
  localparam int QUAL = 100;

  logic clk = 0, rst = 1, sel_a = 0, sel_b = 0, ref1 = 0, ref2 = 0;
  logic lock = 0, hiz = 0;
  logic [FW-1:0] fcw_in = '0;
  logic free_ind, ref1_ind, ref2_ind, hold_ind, ref_sel, pll_track;
  logic pll_unlock, alarm, out_oe;
  logic [FW-1:0] fcw_hold;
  logic en1 = 0, en2 = 0, done = 0;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  refmode_ctrl #(.FCW_W(FW), .LOSS_CYC(LOSS), .QUAL_CYC(QUAL)) u_dut (
    .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b), .ref1_in(ref1),
    .ref2_in(ref2), .pll_lock(lock), .hiz_req(hiz), .fcw_in(fcw_in),
    .free_ind(free_ind), .ref1_ind(ref1_ind), .ref2_ind(ref2_ind),
    .hold_ind(hold_ind), .ref_sel(ref_sel), .pll_track(pll_track),
    .pll_unlock(pll_unlock), .alarm(alarm), .out_oe(out_oe), .fcw_hold(fcw_hold));

  initial forever begin
    repeat (4) @(posedge clk);
    #2 ref1 = en1 ? ~ref1 : 1'b0;
  end
  initial forever begin
    repeat (3) @(posedge clk);
    #2 ref2 = en2 ? ~ref2 : 1'b0;
  end

  // behavioural reference model
  int m_mode = 0;
  int m_alarm = 1;
  int m_fcw = 0;
  int m_hist[2][$];
  int m_idle[2];
  int m_good[2];

  function automatic bit m_lor(int r);
    return (m_idle[r] >= LOSS) || (m_good[r] < QUAL);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_alarm = 1; m_fcw = 0;
      for (int r = 0; r < 2; r++) begin
        m_hist[r] = '{0, 0, 0}; m_idle[r] = 0; m_good[r] = 0;
      end
    end else begin
      bit trk;
      bit lor;
      trk = (m_mode == 1) || (m_mode == 2);
      lor = (m_mode == 2) ? m_lor(1) : m_lor(0);
      m_alarm = (!trk || lor || !lock) ? 1 : 0;
      if (trk && lock) m_fcw = fcw_in;
      m_mode = {sel_b, sel_a};
      for (int r = 0; r < 2; r++) begin
        bit lost_now;
        lost_now = (m_idle[r] >= LOSS);
        if (m_hist[r][1] == 1 && m_hist[r][2] == 0) m_idle[r] = 0;
        else if (!lost_now) m_idle[r]++;
        if (lost_now) m_good[r] = 0;
        else if (m_good[r] < QUAL) m_good[r]++;
        void'(m_hist[r].pop_back());
        m_hist[r].push_front(r == 0 ? int'(ref1) : int'(ref2));
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk("R1 free_ind", free_ind, m_mode == 0);
    chk("R1 ref1_ind", ref1_ind, m_mode == 1);
    chk("R1 ref2_ind", ref2_ind, m_mode == 2);
    chk("R1 hold_ind", hold_ind, m_mode == 3);
    chk("R11 ref_sel", ref_sel, m_mode == 2);
    chk("R11 pll_track", pll_track, (m_mode == 1) || (m_mode == 2));
    chk("R5 pll_unlock", pll_unlock, !lock || !((m_mode == 1) || (m_mode == 2)));
    chk("R4 R6 R7 R8 alarm", alarm, m_alarm);
    chk("R9 out_oe", out_oe, !hiz);
    chk("R10 fcw_hold", int'(fcw_hold), m_fcw);
  end

  always @(posedge clk) #2 fcw_in <= fcw_in + 16'd3;

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask
  task automatic at_neg(string req, int act_sel, int exp);
    @(negedge clk);
    case (act_sel)
      0: chk(req, alarm, exp);
      1: chk(req, free_ind, exp);
      default: chk(req, out_oe, exp);
    endcase
    @(posedge clk); #2;
  endtask

  initial begin
    cyc(3);
    @(negedge clk);
    chk("R2 reset free_ind", free_ind, 1);
    chk("R2 reset alarm", alarm, 1);
    chk("R2 reset fcw_hold", int'(fcw_hold), 0);
    @(posedge clk); #2 rst = 0;
    cyc(10);
    at_neg("R4 alarm in free run", 0, 1);
    sel_a = 1; sel_b = 1; cyc(10);
    at_neg("R4 alarm in holdover", 0, 1);
    // lock to reference 1
    sel_a = 1; sel_b = 0; en1 = 1; en2 = 1; lock = 1;
    cyc(QUAL + 40);
    at_neg("R7 qualified reference clears alarm", 0, 0);
    en2 = 0; cyc(LOSS + 30);
    at_neg("R8 unselected reference loss ignored", 0, 0);
    en2 = 1;
    lock = 0; cyc(2);
    at_neg("R5 unlock raises alarm", 0, 1);
    lock = 1; cyc(3);
    at_neg("R5 lock restored clears alarm", 0, 0);
    // loss timing
    en1 = 0; cyc(LOSS - 7);
    at_neg("R6 no alarm before window", 0, 0);
    cyc(15);
    at_neg("R6 alarm after window", 0, 1);
    // release timing
    en1 = 1; cyc(QUAL - 3);
    at_neg("R7 alarm held during qualification", 0, 1);
    cyc(20);
    at_neg("R7 alarm cleared after qualification", 0, 0);
    // restart of qualification
    en1 = 0; cyc(LOSS + 20);
    en1 = 1; cyc(QUAL / 2);
    en1 = 0; cyc(LOSS + 20);
    en1 = 1; cyc(QUAL - 3);
    at_neg("R7 qualification restarted by loss", 0, 1);
    cyc(20);
    at_neg("R7 clears after full restart", 0, 0);
    // reference 2
    sel_a = 0; sel_b = 1; cyc(QUAL + 20);
    en2 = 0; cyc(LOSS + 20);
    at_neg("R6 reference 2 loss alarm", 0, 1);
    en2 = 1; cyc(QUAL + 20);
    // holdover freeze
    sel_a = 1; sel_b = 1; cyc(30);
    hiz = 1; cyc(1);
    at_neg("R9 tri-state request", 2, 0);
    hiz = 0; cyc(1);
    // random control patterns
    for (int i = 0; i < 300; i++) begin
      sel_a = $urandom_range(0, 1);
      sel_b = $urandom_range(0, 1);
      lock  = ($urandom_range(0, 7) != 0);
      hiz   = ($urandom_range(0, 5) == 0);
      if (i % 40 == 0) en1 = ~en1;
      if (i % 55 == 0) en2 = ~en2;
      cyc($urandom_range(1, 6));
    end
    rst = 1; cyc(2);
    at_neg("R2 reset back to free run", 1, 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule